// File: doc/BRIEF.md
# CAN Controller Host Register Block

This block is the byte-wide register file through which a host processor controls a CAN controller that runs in its extended register layout. It keeps the mode, status, interrupt, interrupt-enable and clock-divider registers. It turns command writes into single-cycle pulses for the transmit engine and the receive FIFO. It drives one level-sensitive interrupt line. The bus engine, the FIFO storage and the acceptance filter sit outside the block and connect through plain ports.

A shared window of thirteen addresses, starting at 16, changes meaning with the reset-mode bit (bit 0 of the mode register). While that bit is set, the first eight window addresses hold the acceptance code and mask bytes, which go to the filter as a flat vector. While it is clear, window writes go out as transmit-buffer byte writes, and window reads return the byte the FIFO presents for the requested offset. The interrupt register clears when it is read. If the FIFO still reports stored messages, the receive flag comes back at once.

Top module: `can_host_regs`

## Requirements
- R1: After reset the mode reads 0x01, status reads 0x3C, interrupt, interrupt-enable and clock divider read 0x00, and `irq` and all command pulses are low.
- R2: `irq` is high exactly when the interrupt-enable register (address 4) and the interrupt register (address 3) have a set bit in common.
- R3: A read of address 3 returns the interrupt bits and clears them. Bit 0 is set again when `rx_msg_count` is nonzero. Event inputs that arrive in the same cycle as the read are kept.
- R4: A write to address 1 with bit 0 set pulses `tx_req` for one cycle and clears status bits 3 and 2. Bit 2 pulses `rx_release` only when `rx_msg_count` is nonzero, and clears status bit 0 and interrupt bit 0 when the count is 1. Bit 3 pulses `ovr_clear` and clears status bit 1 and interrupt bit 3. Address 1 reads as 0.
- R5: A `tx_done` pulse sets status bits 3 and 2, clears status bit 5 and sets interrupt bit 1.
- R6: An `rx_stored` pulse sets status bit 0 and interrupt bit 0. An `rx_overrun` pulse sets status bit 1 and interrupt bit 3.
- R7: Any write to address 16 sets status bit 5.
- R8: In reset mode, addresses 16..23 read and write the eight code/mask bytes, 24..28 read 0, and window writes produce no `tx_wr_en`.
- R9: In operation mode, a write to address 16+k gives `tx_wr_en` with `tx_wr_idx`=k and the written byte. A read of 16+k drives `rx_win_idx`=k and returns `rx_win_data`.
- R10: A mode write stores only data bits 4..0. The upper three bits read as 0.
- R11: Writes to status (2) and interrupt (3) have no effect. Addresses 5..15 read 0x00, 29 and 30 read 0xFF, and 31 is a read/write clock-divider byte.
- R12: `host_rdata` changes only at the clock edge that samples `host_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 5 | Register byte address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |
| mode_bits | output | 5 | Current mode register |
| clk_div | output | 8 | Clock divider register |
| acc_bytes | output | 64 | Code/mask bytes, byte k at bits 8k+7..8k |
| tx_req | output | 1 | Transmit request pulse |
| rx_release | output | 1 | Receive buffer release pulse |
| ovr_clear | output | 1 | Clear-overrun pulse |
| tx_done | input | 1 | Transmit finished pulse from bus engine |
| tx_wr_en | output | 1 | Transmit buffer byte write |
| tx_wr_idx | output | 4 | Transmit buffer byte offset |
| tx_wr_data | output | 8 | Transmit buffer byte |
| rx_msg_count | input | 6 | Messages held in receive FIFO |
| rx_stored | input | 1 | FIFO accepted a message pulse |
| rx_overrun | input | 1 | FIFO overrun pulse |
| rx_win_idx | output | 4 | Receive window byte offset |
| rx_win_data | input | 8 | Receive window byte from FIFO |

## Verification
Each register update, command pulse, transmit-buffer write and read result shows up one clock edge after the strobe or event input that causes it. `irq` follows the updated registers with no further delay, and `rx_win_idx` follows the address with no delay. The bench drives every input on the falling edge and samples on the next falling edge, which falls between the edge that updates the state and the edge after it. Pulse widths are checked on the falling edge after that one. For read-data timing, the bench looks at `host_rdata` inside the half cycle before the sampling edge, where it must still hold the previous result.

// File: rtl/can_host_pkg.sv
package can_host_pkg;

   typedef enum logic [3:0] {
      RG_MODE,
      RG_CMD,
      RG_STAT,
      RG_IRQ,
      RG_IEN,
      RG_ZERO,
      RG_WIN,
      RG_CLKDIV,
      RG_NONE
   } reg_sel_e;

   localparam int unsigned ADR_MODE   = 0;
   localparam int unsigned ADR_CMD    = 1;
   localparam int unsigned ADR_STAT   = 2;
   localparam int unsigned ADR_IRQ    = 3;
   localparam int unsigned ADR_IEN    = 4;
   localparam int unsigned ADR_WIN    = 16;
   localparam int unsigned LEN_WIN    = 13;
   localparam int unsigned ADR_CLKDIV = 31;

   localparam int unsigned ST_RXBUF  = 0;
   localparam int unsigned ST_OVR    = 1;
   localparam int unsigned ST_TXFREE = 2;
   localparam int unsigned ST_TXDONE = 3;
   localparam int unsigned ST_TXACT  = 5;

   localparam int unsigned IR_RX  = 0;
   localparam int unsigned IR_TX  = 1;
   localparam int unsigned IR_OVR = 3;

   localparam int unsigned CMD_TX  = 0;
   localparam int unsigned CMD_REL = 2;
   localparam int unsigned CMD_CLR = 3;

   localparam logic [7:0] STAT_RST = 8'h3C;

endpackage

// File: rtl/can_host_decode.sv
module can_host_decode
   import can_host_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int WIN_BASE  = 16,
   parameter int WIN_LEN   = 13,
   parameter int CLK_ADDR  = 31,
   localparam int WIN_IDX_W = $clog2(WIN_LEN)
) (
   input  logic [ADDR_W-1:0]    addr,
   output reg_sel_e             sel,
   output logic [WIN_IDX_W-1:0] win_idx
);

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(ADR_CMD);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
   localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(ADR_IRQ);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(ADR_IEN);
   localparam logic [ADDR_W-1:0] A_WLO  = ADDR_W'(WIN_BASE);
   localparam logic [ADDR_W-1:0] A_WHI  = ADDR_W'(WIN_BASE + WIN_LEN - 1);
   localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(CLK_ADDR);

   logic [ADDR_W-1:0] offset;

   assign offset = addr - A_WLO;

   always_comb begin
      sel     = RG_NONE;
      win_idx = '0;
      if (addr == A_MODE)      sel = RG_MODE;
      else if (addr == A_CMD)  sel = RG_CMD;
      else if (addr == A_STAT) sel = RG_STAT;
      else if (addr == A_IRQ)  sel = RG_IRQ;
      else if (addr == A_IEN)  sel = RG_IEN;
      else if (addr < A_WLO)   sel = RG_ZERO;
      else if (addr <= A_WHI) begin
         sel     = RG_WIN;
         win_idx = offset[WIN_IDX_W-1:0];
      end
      else if (addr == A_CLK)  sel = RG_CLKDIV;
   end

endmodule

// File: rtl/can_host_accept_bank.sv
module can_host_accept_bank #(
   parameter int DATA_W    = 8,
   parameter int NBYTES    = 8,
   parameter int IDX_W     = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [DATA_W-1:0]        rdata,
   output logic [NBYTES*DATA_W-1:0] flat
);

   logic [DATA_W-1:0] bytes_q [NBYTES];

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bytes_q[g] <= '0;
         end else if (we && (wr_idx == IDX_W'(g))) begin
            bytes_q[g] <= wdata;
         end
      end
      assign flat[g*DATA_W +: DATA_W] = bytes_q[g];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (rd_idx == IDX_W'(i)) rdata = bytes_q[i];
      end
   end

endmodule

// File: rtl/can_host_event_regs.sv
module can_host_event_regs
   import can_host_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_cmd,
   input  logic              tx_done,
   input  logic              wr_first,
   input  logic              rel_last,
   input  logic              ovr_clr,
   input  logic              rx_stored,
   input  logic              rx_overrun,
   input  logic              ir_rd,
   input  logic              msg_pending,
   input  logic              ien_we,
   input  logic [DATA_W-1:0] ien_wdata,
   output logic [DATA_W-1:0] stat_q,
   output logic [DATA_W-1:0] ir_q,
   output logic [DATA_W-1:0] ien_q,
   output logic              irq
);

   logic [DATA_W-1:0] stat_d;
   logic [DATA_W-1:0] ir_d;

   // Host-side clears are applied first; hardware events then set on top,
   // so an event landing in the same cycle as a clear is never lost.
   always_comb begin
      stat_d = stat_q;
      if (tx_cmd) begin
         stat_d[ST_TXDONE] = 1'b0;
         stat_d[ST_TXFREE] = 1'b0;
      end
      if (wr_first)   stat_d[ST_TXACT] = 1'b1;
      if (rel_last)   stat_d[ST_RXBUF] = 1'b0;
      if (ovr_clr)    stat_d[ST_OVR]   = 1'b0;
      if (tx_done) begin
         stat_d[ST_TXDONE] = 1'b1;
         stat_d[ST_TXFREE] = 1'b1;
         stat_d[ST_TXACT]  = 1'b0;
      end
      if (rx_stored)  stat_d[ST_RXBUF] = 1'b1;
      if (rx_overrun) stat_d[ST_OVR]   = 1'b1;
   end

   always_comb begin
      ir_d = ir_q;
      if (ir_rd) begin
         ir_d        = '0;
         ir_d[IR_RX] = msg_pending;
      end
      if (rel_last)   ir_d[IR_RX]  = 1'b0;
      if (ovr_clr)    ir_d[IR_OVR] = 1'b0;
      if (tx_done)    ir_d[IR_TX]  = 1'b1;
      if (rx_stored)  ir_d[IR_RX]  = 1'b1;
      if (rx_overrun) ir_d[IR_OVR] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= DATA_W'(STAT_RST);
         ir_q   <= '0;
         ien_q  <= '0;
      end else begin
         stat_q <= stat_d;
         ir_q   <= ir_d;
         if (ien_we) ien_q <= ien_wdata;
      end
   end

   assign irq = |(ien_q & ir_q);

endmodule

// File: rtl/can_host_regs.sv
module can_host_regs
   import can_host_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 8,
   parameter int MODE_W    = 5,
   parameter int CNT_W     = 6,
   parameter int ACC_BYTES = 8,
   parameter int WIN_BASE  = ADR_WIN,
   parameter int WIN_LEN   = LEN_WIN,
   parameter int CLK_ADDR  = ADR_CLKDIV,
   localparam int WIN_IDX_W = $clog2(WIN_LEN)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        host_wr,
   input  logic                        host_rd,
   input  logic [ADDR_W-1:0]           host_addr,
   input  logic [DATA_W-1:0]           host_wdata,
   output logic [DATA_W-1:0]           host_rdata,
   output logic                        irq,
   output logic [MODE_W-1:0]           mode_bits,
   output logic [DATA_W-1:0]           clk_div,
   output logic [ACC_BYTES*DATA_W-1:0] acc_bytes,
   output logic                        tx_req,
   output logic                        rx_release,
   output logic                        ovr_clear,
   input  logic                        tx_done,
   output logic                        tx_wr_en,
   output logic [WIN_IDX_W-1:0]        tx_wr_idx,
   output logic [DATA_W-1:0]           tx_wr_data,
   input  logic [CNT_W-1:0]            rx_msg_count,
   input  logic                        rx_stored,
   input  logic                        rx_overrun,
   output logic [WIN_IDX_W-1:0]        rx_win_idx,
   input  logic [DATA_W-1:0]           rx_win_data
);

   if (DATA_W != 8) begin : g_bad_data
      $error("can_host_regs: DATA_W must be 8");
   end
   if (MODE_W > DATA_W || MODE_W < 1) begin : g_bad_mode
      $error("can_host_regs: MODE_W out of range");
   end
   if (ACC_BYTES > WIN_LEN) begin : g_bad_acc
      $error("can_host_regs: code/mask bytes exceed window");
   end
   if (WIN_BASE + WIN_LEN > CLK_ADDR || CLK_ADDR >= (1 << ADDR_W)) begin : g_bad_map
      $error("can_host_regs: address map does not fit");
   end
   if (WIN_BASE <= int'(ADR_IEN)) begin : g_bad_base
      $error("can_host_regs: window overlaps control registers");
   end

   reg_sel_e             sel;
   logic [WIN_IDX_W-1:0] win_idx;

   can_host_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_BASE (WIN_BASE),
      .WIN_LEN  (WIN_LEN),
      .CLK_ADDR (CLK_ADDR)
   ) u_dec (
      .addr    (host_addr),
      .sel     (sel),
      .win_idx (win_idx)
   );

   logic [MODE_W-1:0] mode_q;
   logic [DATA_W-1:0] clk_q;
   logic              in_reset_mode;

   assign in_reset_mode = mode_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_W'(1);
         clk_q  <= '0;
      end else begin
         if (host_wr && sel == RG_MODE)   mode_q <= host_wdata[MODE_W-1:0];
         if (host_wr && sel == RG_CLKDIV) clk_q  <= host_wdata;
      end
   end

   assign mode_bits = mode_q;
   assign clk_div   = clk_q;

   logic win_wr;
   logic acc_we;
   logic acc_hit;

   assign win_wr  = host_wr && (sel == RG_WIN);
   assign acc_hit = (32'(win_idx) < ACC_BYTES);
   assign acc_we  = win_wr && in_reset_mode && acc_hit;

   logic [DATA_W-1:0] acc_rd;

   can_host_accept_bank #(
      .DATA_W (DATA_W),
      .NBYTES (ACC_BYTES),
      .IDX_W  (WIN_IDX_W)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (acc_we),
      .wr_idx (win_idx),
      .wdata  (host_wdata),
      .rd_idx (win_idx),
      .rdata  (acc_rd),
      .flat   (acc_bytes)
   );

   logic cmd_wr;
   logic do_tx;
   logic do_rel;
   logic do_clr;
   logic msg_pending;
   logic rel_last;

   assign cmd_wr      = host_wr && (sel == RG_CMD);
   assign msg_pending = (rx_msg_count != '0);
   assign do_tx       = cmd_wr && host_wdata[CMD_TX];
   assign do_rel      = cmd_wr && host_wdata[CMD_REL] && msg_pending;
   assign do_clr      = cmd_wr && host_wdata[CMD_CLR];
   assign rel_last    = do_rel && (rx_msg_count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_req     <= 1'b0;
         rx_release <= 1'b0;
         ovr_clear  <= 1'b0;
         tx_wr_en   <= 1'b0;
         tx_wr_idx  <= '0;
         tx_wr_data <= '0;
      end else begin
         tx_req     <= do_tx;
         rx_release <= do_rel;
         ovr_clear  <= do_clr;
         tx_wr_en   <= win_wr && !in_reset_mode;
         if (win_wr && !in_reset_mode) begin
            tx_wr_idx  <= win_idx;
            tx_wr_data <= host_wdata;
         end
      end
   end

   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] ien_q;

   can_host_event_regs #(
      .DATA_W (DATA_W)
   ) u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_cmd      (do_tx),
      .tx_done     (tx_done),
      .wr_first    (win_wr && (win_idx == '0)),
      .rel_last    (rel_last),
      .ovr_clr     (do_clr),
      .rx_stored   (rx_stored),
      .rx_overrun  (rx_overrun),
      .ir_rd       (host_rd && (sel == RG_IRQ)),
      .msg_pending (msg_pending),
      .ien_we      (host_wr && (sel == RG_IEN)),
      .ien_wdata   (host_wdata),
      .stat_q      (stat_q),
      .ir_q        (ir_q),
      .ien_q       (ien_q),
      .irq         (irq)
   );

   assign rx_win_idx = win_idx;

   logic [DATA_W-1:0] rd_val;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      unique case (sel)
         RG_MODE:   rd_val = DATA_W'(mode_q);
         RG_CMD:    rd_val = '0;
         RG_STAT:   rd_val = stat_q;
         RG_IRQ:    rd_val = ir_q;
         RG_IEN:    rd_val = ien_q;
         RG_ZERO:   rd_val = '0;
         RG_WIN:    rd_val = in_reset_mode ? acc_rd : rx_win_data;
         RG_CLKDIV: rd_val = clk_q;
         default:   rd_val = '1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (host_rd) rdata_q <= rd_val;
   end

   assign host_rdata = rdata_q;

endmodule

// File: rtl/can_host_regs_chk.sv
module can_host_regs_chk
   import can_host_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int MODE_W = 5,
   parameter int CNT_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic [DATA_W-1:0] host_rdata,
   input logic              irq,
   input logic [MODE_W-1:0] mode_bits,
   input logic              tx_req,
   input logic              rx_release,
   input logic              tx_done,
   input logic              tx_wr_en,
   input logic [CNT_W-1:0]  rx_msg_count,
   input logic              rx_stored,
   input logic              rx_overrun
);

   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(ADR_CMD);
   localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(ADR_IRQ);
   localparam logic [ADDR_W-1:0] A_WLO = ADDR_W'(ADR_WIN);
   localparam logic [ADDR_W-1:0] A_WHI = ADDR_W'(ADR_WIN + LEN_WIN - 1);
   localparam logic [ADDR_W-1:0] A_U0  = ADDR_W'(ADR_WIN + LEN_WIN);
   localparam logic [ADDR_W-1:0] A_U1  = ADDR_W'(ADR_WIN + LEN_WIN + 1);

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         rst_quiet_chk: assert (!irq && !tx_req && !rx_release);
      end
   end

   // R4
   tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == A_CMD && host_wdata[CMD_TX]) |=> tx_req);

   // R4
   rel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == A_CMD && rx_msg_count == '0) |=> !rx_release);

   // R4
   cmd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == A_CMD) |=> (host_rdata == '0));

   // R3
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == A_IRQ && rx_msg_count == '0 &&
       !rx_stored && !rx_overrun && !tx_done) |=> !irq);

   // R8
   acc_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && mode_bits[0] && host_addr >= A_WLO && host_addr <= A_WHI) |=> !tx_wr_en);

   // R11
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && (host_addr == A_U0 || host_addr == A_U1)) |=> (host_rdata == '1));

   // R12
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> $stable(host_rdata));

endmodule

bind can_host_regs can_host_regs_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .MODE_W (MODE_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_wr      (host_wr),
   .host_rd      (host_rd),
   .host_addr    (host_addr),
   .host_wdata   (host_wdata),
   .host_rdata   (host_rdata),
   .irq          (irq),
   .mode_bits    (mode_bits),
   .tx_req       (tx_req),
   .rx_release   (rx_release),
   .tx_done      (tx_done),
   .tx_wr_en     (tx_wr_en),
   .rx_msg_count (rx_msg_count),
   .rx_stored    (rx_stored),
   .rx_overrun   (rx_overrun)
);

// File: tb/can_host_regs_tb.sv
`timescale 1ns/1ps
module can_host_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        irq;
   logic [4:0]  mode_bits;
   logic [7:0]  clk_div;
   logic [63:0] acc_bytes;
   logic        tx_req, rx_release, ovr_clear;
   logic        tx_done = 1'b0;
   logic        tx_wr_en;
   logic [3:0]  tx_wr_idx;
   logic [7:0]  tx_wr_data;
   logic [5:0]  rx_msg_count = '0;
   logic        rx_stored = 1'b0;
   logic        rx_overrun = 1'b0;
   logic [3:0]  rx_win_idx;
   logic [7:0]  rx_win_data;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign rx_win_data = 8'hA0 ^ {4'h0, rx_win_idx};

   can_host_regs u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .mode_bits(mode_bits), .clk_div(clk_div), .acc_bytes(acc_bytes),
      .tx_req(tx_req), .rx_release(rx_release), .ovr_clear(ovr_clear),
      .tx_done(tx_done), .tx_wr_en(tx_wr_en), .tx_wr_idx(tx_wr_idx),
      .tx_wr_data(tx_wr_data), .rx_msg_count(rx_msg_count), .rx_stored(rx_stored),
      .rx_overrun(rx_overrun), .rx_win_idx(rx_win_idx), .rx_win_data(rx_win_data)
   );

   // fields: tag[26:23] wr[22] rd[21] addr[20:16] wdata[15:8] expect[7:0]
   localparam int NV = 30;
   localparam logic [26:0] VEC [NV] = '{
      {4'd1,  1'b0, 1'b1, 5'd0,  8'h00, 8'h01},  // R1 mode
      {4'd1,  1'b0, 1'b1, 5'd2,  8'h00, 8'h3C},  // R1 status
      {4'd1,  1'b0, 1'b1, 5'd3,  8'h00, 8'h00},  // R1 interrupt
      {4'd1,  1'b0, 1'b1, 5'd4,  8'h00, 8'h00},  // R1 enable
      {4'd1,  1'b0, 1'b1, 5'd31, 8'h00, 8'h00},  // R1 divider
      {4'd4,  1'b0, 1'b1, 5'd1,  8'h00, 8'h00},  // R4 command reads 0
      {4'd8,  1'b1, 1'b0, 5'd17, 8'hAA, 8'h00},  // R8
      {4'd8,  1'b0, 1'b1, 5'd17, 8'h00, 8'hAA},  // R8
      {4'd8,  1'b1, 1'b0, 5'd23, 8'h55, 8'h00},  // R8
      {4'd8,  1'b0, 1'b1, 5'd23, 8'h00, 8'h55},  // R8
      {4'd8,  1'b0, 1'b1, 5'd24, 8'h00, 8'h00},  // R8
      {4'd8,  1'b0, 1'b1, 5'd28, 8'h00, 8'h00},  // R8
      {4'd11, 1'b1, 1'b0, 5'd2,  8'hFF, 8'h00},  // R11
      {4'd11, 1'b0, 1'b1, 5'd2,  8'h00, 8'h3C},  // R11
      {4'd11, 1'b1, 1'b0, 5'd3,  8'hFF, 8'h00},  // R11
      {4'd11, 1'b0, 1'b1, 5'd3,  8'h00, 8'h00},  // R11
      {4'd11, 1'b0, 1'b1, 5'd9,  8'h00, 8'h00},  // R11
      {4'd11, 1'b0, 1'b1, 5'd15, 8'h00, 8'h00},  // R11
      {4'd11, 1'b0, 1'b1, 5'd29, 8'h00, 8'hFF},  // R11
      {4'd11, 1'b0, 1'b1, 5'd30, 8'h00, 8'hFF},  // R11
      {4'd11, 1'b1, 1'b0, 5'd31, 8'hC3, 8'h00},  // R11
      {4'd11, 1'b0, 1'b1, 5'd31, 8'h00, 8'hC3},  // R11
      {4'd11, 1'b1, 1'b0, 5'd4,  8'h0B, 8'h00},  // R11 enable
      {4'd11, 1'b0, 1'b1, 5'd4,  8'h00, 8'h0B},  // R11
      {4'd10, 1'b1, 1'b0, 5'd0,  8'hFE, 8'h00},  // R10
      {4'd10, 1'b0, 1'b1, 5'd0,  8'h00, 8'h1E},  // R10
      {4'd10, 1'b1, 1'b0, 5'd0,  8'h08, 8'h00},  // R10
      {4'd10, 1'b0, 1'b1, 5'd0,  8'h00, 8'h08},  // R10
      {4'd9,  1'b0, 1'b1, 5'd18, 8'h00, 8'hA2},  // R9
      {4'd9,  1'b0, 1'b1, 5'd28, 8'h00, 8'hAC}   // R9
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] v);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd = 1'b0;
      v = host_rdata;
   endtask

   task automatic pulse_ev(input int which);
      @(negedge clk);
      if (which == 0) tx_done = 1'b1;
      if (which == 1) rx_stored = 1'b1;
      if (which == 2) rx_overrun = 1'b1;
      @(negedge clk);
      tx_done = 1'b0; rx_stored = 1'b0; rx_overrun = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      // R1 outputs quiet under reset
      check("R1 irq", irq, 0);
      check("R1 tx_req", tx_req, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][22]) wr(VEC[i][20:16], VEC[i][15:8]);
         if (VEC[i][21]) begin
            rd(VEC[i][20:16], v);
            check($sformatf("R%0d vec %0d", VEC[i][26:23], i), v, VEC[i][7:0]);
         end
      end

      // R8: window write in reset mode does not reach transmit port
      wr(5'd0, 8'h01);
      wr(5'd20, 8'h77);
      check("R8 no tx write", tx_wr_en, 0);
      rd(5'd20, v);
      check("R8 code byte", v, 8'h77);
      check("R8 flat byte 4", acc_bytes[39:32], 8'h77);
      wr(5'd0, 8'h08);

      // R9: transmit buffer write in operation mode
      wr(5'd21, 8'h88);
      check("R9 tx_wr_en", tx_wr_en, 1);
      check("R9 tx_wr_idx", tx_wr_idx, 5);
      check("R9 tx_wr_data", tx_wr_data, 8'h88);

      // R4 transmit command
      wr(5'd1, 8'h01);
      check("R4 tx_req high", tx_req, 1);
      @(negedge clk);
      check("R4 tx_req one cycle", tx_req, 0);
      rd(5'd2, v);
      check("R4 status after tx cmd", v, 8'h30);
      // R5 transmit completion
      pulse_ev(0);
      check("R5 irq", irq, 1);
      rd(5'd2, v);
      check("R5 status", v, 8'h1C);
      // R3 read clears
      rd(5'd3, v);
      check("R3 ir value", v, 8'h02);
      check("R3 irq low", irq, 0);
      rd(5'd3, v);
      check("R3 ir cleared", v, 8'h00);
      // R7
      wr(5'd16, 8'h11);
      rd(5'd2, v);
      check("R7 status bit5", v, 8'h3C);

      // R6 receive event
      rx_msg_count = 6'd1;
      pulse_ev(1);
      check("R6 irq", irq, 1);
      rd(5'd2, v);
      check("R6 status rx", v, 8'h3D);
      rd(5'd3, v);
      check("R3 ir rx", v, 8'h01);
      rd(5'd3, v);
      check("R3 rx reasserted", v, 8'h01);
      pulse_ev(2);
      rd(5'd2, v);
      check("R6 status overrun", v, 8'h3F);
      // R4 clear overrun
      wr(5'd1, 8'h08);
      check("R4 ovr_clear", ovr_clear, 1);
      rd(5'd2, v);
      check("R4 status after clear", v, 8'h3D);
      rd(5'd3, v);
      check("R4 ir after clear", v, 8'h01);
      // R4 release last message
      wr(5'd1, 8'h04);
      check("R4 rx_release", rx_release, 1);
      rx_msg_count = 6'd0;
      check("R4 irq after release", irq, 0);
      rd(5'd2, v);
      check("R4 status after release", v, 8'h3C);
      rd(5'd3, v);
      check("R4 ir after release", v, 8'h00);
      wr(5'd1, 8'h04);
      check("R4 no release when empty", rx_release, 0);

      // R2 enable masking
      wr(5'd4, 8'h00);
      pulse_ev(2);
      check("R2 masked", irq, 0);
      wr(5'd4, 8'h08);
      check("R2 enabled", irq, 1);
      wr(5'd1, 8'h08);
      check("R2 cleared", irq, 0);

      // R3 event in same cycle as read
      @(negedge clk);
      host_rd = 1'b1; host_addr = 5'd3; rx_overrun = 1'b1;
      @(negedge clk);
      host_rd = 1'b0; rx_overrun = 1'b0;
      check("R3 old value", host_rdata, 8'h00);
      rd(5'd3, v);
      check("R3 event kept", v, 8'h08);

      // R12 read data changes only at the edge
      @(negedge clk);
      host_rd = 1'b1; host_addr = 5'd31;
      #1;
      check("R12 hold before edge", host_rdata, 8'h08);
      @(negedge clk);
      host_rd = 1'b0;
      check("R12 new value", host_rdata, 8'hC3);
      @(negedge clk);
      check("R12 held", host_rdata, 8'hC3);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule